// File: doc/BRIEF.md
# Interrupt Prioritizer with Fixed and Programmable Source Entries

This block sits between fifteen interrupt request lines and a processor core. Each source owns a control entry made of a 3-bit level and a 4-bit priority used to rank sources that share a level. The first seven sources have hardwired entries: source n sits at level n with priority 8, and software cannot change them. Sources 8 to 15 have entries that software writes over a small register bus. Any level from 1 to 7 and any priority can be assigned to them. Writing level 0 to one of these entries takes that source out of arbitration.

A per-source mask register, also on the register bus, can block any source, including those at level 7. No path bypasses the mask. Every cycle the block picks the best pending, unmasked and enabled source. It raises a request when that source's level is above the processor's current mask level. Level 7 is the exception: it is taken whenever it is unmasked. Level, source number and the valid flag come from registers.

Software is expected to give every source a distinct level/priority pair. When a pair is duplicated anyway, the lower source number wins, so the result stays deterministic.

Top module: `irq_prioritizer`

## Requirements
- R1: Reading address n (1 to 7) returns level n in bits [6:4] and priority 8 in bits [3:0], with all other bits zero. Source n then takes part in arbitration at that level and priority.
- R2: A write to any address from 1 to 7 has no effect. The readback and the arbitration result stay the same as before the write.
- R3: Address n (8 to 15) holds source n's entry, with the level in bits [6:4] and the priority in bits [3:0]. A write stores both fields, and a read returns them. These entries reset to zero.
- R4: Address 0 is the mask register, where bit n-1 masks source n. It resets to all ones. A masked source never produces a request, even at level 7.
- R5: Among pending, unmasked and enabled sources, the highest level wins. Within one level, the higher priority value wins.
- R6: When two eligible sources hold the same level/priority pair, the lower source number wins.
- R7: A request is raised only when the winning level is greater than the 3-bit processor mask input. Level 7 is raised even when the processor mask is 7.
- R8: A programmable source whose level is 0 never wins and never raises a request.
- R9: The outputs are registered. They change on the first clock edge after the pending inputs, mask input or an entry change. In reset, and whenever no request is raised, valid, level and source are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | 15 | Pending request per source, bit n-1 is source n |
| cpu_mask_i | input | 3 | Current processor interrupt mask level |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address: 0 mask, n entry of source n |
| reg_wdata_i | input | 15 | Register write data |
| reg_rdata_o | output | 15 | Register read data for reg_addr_i (combinational) |
| irq_valid_o | output | 1 | Interrupt request to the core |
| irq_level_o | output | 3 | Level of the granted source |
| irq_src_o | output | 4 | Number of the granted source (1 to 15) |

## Verification
Some properties are checked on every cycle. The readback of the hardwired entries must always show level n with priority 8. A granted source must have been pending and unmasked on the cycle before. A grant must clear the previous processor mask or be at level 7. The outputs must be all zero whenever no grant is made.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent model:
- the ranking by level and then by priority;
- the lower-number rule for duplicated pairs;
- a write to a hardwired entry being ignored;
- level 0 disabling a programmable source;
- the one-cycle output latency.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

   localparam int LVL_W = 3;
   localparam int PRI_W = 4;
   localparam int KEY_W = LVL_W + PRI_W;

   // Level in the upper bits so that a plain compare ranks level first
   typedef struct packed {
      logic [LVL_W-1:0] lvl;
      logic [PRI_W-1:0] pri;
   } prio_key_t;

endpackage

// File: rtl/irq_prio_cfg.sv
module irq_prio_cfg
   import irq_prio_pkg::*;
#(
   parameter int N_SRC     = 15,
   parameter int N_FIXED   = 7,
   parameter int FIXED_PRI = 8,
   parameter int DATA_W    = 15,
   parameter int ADDR_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output prio_key_t         key_o [N_SRC],
   output logic [N_SRC-1:0]  mask_o
);

   // Per-source entry: hardwired for the low group, a register for the rest
   for (genvar i = 0; i < N_SRC; i++) begin : g_entry
      if (i < N_FIXED) begin : g_fixed
         assign key_o[i] = '{lvl: LVL_W'(i + 1), pri: PRI_W'(FIXED_PRI)};
      end else begin : g_prog
         prio_key_t key_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               key_q <= '0;
            else if (wr_en && addr == ADDR_W'(i + 1))
               key_q <= wdata[KEY_W-1:0];
         end
         assign key_o[i] = key_q;
      end
   end

   // Mask register: every source starts blocked
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mask_o <= '1;
      else if (wr_en && addr == '0)
         mask_o <= wdata[N_SRC-1:0];
   end

   always_comb begin
      rdata = '0;
      if (addr == '0)
         rdata[N_SRC-1:0] = mask_o;
      for (int i = 0; i < N_SRC; i++) begin
         if (addr == ADDR_W'(i + 1))
            rdata[KEY_W-1:0] = key_o[i];
      end
   end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
   import irq_prio_pkg::*;
#(
   parameter int N_SRC = 15,
   parameter int IDX_W = 4
) (
   input  logic [N_SRC-1:0] elig_i,
   input  prio_key_t        key_i [N_SRC],
   output logic             found_o,
   output prio_key_t        best_o,
   output logic [IDX_W-1:0] idx_o
);

   // Scan from the top source down; ">=" lets a lower number take a tie
   always_comb begin
      found_o = 1'b0;
      best_o  = '0;
      idx_o   = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (elig_i[i] && (!found_o || key_i[i] >= best_o)) begin
            found_o = 1'b1;
            best_o  = key_i[i];
            idx_o   = IDX_W'(i + 1);
         end
      end
   end

endmodule

// File: rtl/irq_prioritizer.sv
module irq_prioritizer
   import irq_prio_pkg::*;
#(
   parameter int N_SRC     = 15,
   parameter int N_FIXED   = 7,
   parameter int FIXED_PRI = 8,
   parameter int DATA_W    = 15,
   localparam int IDX_W    = $clog2(N_SRC + 1),
   localparam int ADDR_W   = IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  pend_i,
   input  logic [LVL_W-1:0]  cpu_mask_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_valid_o,
   output logic [LVL_W-1:0]  irq_level_o,
   output logic [IDX_W-1:0]  irq_src_o
);

   localparam logic [LVL_W-1:0] TOP_LVL = '1;

   if (N_FIXED > N_SRC || N_FIXED >= (1 << LVL_W)) begin : g_bad_fixed
      $error("irq_prioritizer: N_FIXED out of range");
   end
   if (DATA_W < N_SRC || DATA_W < KEY_W) begin : g_bad_data
      $error("irq_prioritizer: DATA_W too narrow");
   end
   if (FIXED_PRI >= (1 << PRI_W)) begin : g_bad_pri
      $error("irq_prioritizer: FIXED_PRI does not fit");
   end

   prio_key_t        src_key [N_SRC];
   logic [N_SRC-1:0] src_mask;
   logic [N_SRC-1:0] elig;
   logic             found;
   prio_key_t        best;
   logic [IDX_W-1:0] best_idx;
   logic             take;

   irq_prio_cfg #(
      .N_SRC(N_SRC), .N_FIXED(N_FIXED), .FIXED_PRI(FIXED_PRI),
      .DATA_W(DATA_W), .ADDR_W(ADDR_W)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (reg_we_i),
      .addr  (reg_addr_i),
      .wdata (reg_wdata_i),
      .rdata (reg_rdata_o),
      .key_o (src_key),
      .mask_o(src_mask)
   );

   for (genvar i = 0; i < N_SRC; i++) begin : g_elig
      assign elig[i] = pend_i[i] && !src_mask[i] && (src_key[i].lvl != '0);
   end

   irq_prio_pick #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_pick (
      .elig_i (elig),
      .key_i  (src_key),
      .found_o(found),
      .best_o (best),
      .idx_o  (best_idx)
   );

   assign take = found && (best.lvl > cpu_mask_i || best.lvl == TOP_LVL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid_o <= 1'b0;
         irq_level_o <= '0;
         irq_src_o   <= '0;
      end else begin
         irq_valid_o <= take;
         irq_level_o <= take ? best.lvl : '0;
         irq_src_o   <= take ? best_idx : '0;
      end
   end

endmodule

module irq_prioritizer_chk
   import irq_prio_pkg::*;
#(
   parameter int N_SRC     = 15,
   parameter int N_FIXED   = 7,
   parameter int FIXED_PRI = 8,
   parameter int DATA_W    = 15,
   parameter int IDX_W     = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  pend_i,
   input logic [LVL_W-1:0]  cpu_mask_i,
   input logic [N_SRC-1:0]  src_mask,
   input logic [IDX_W-1:0]  reg_addr_i,
   input logic [DATA_W-1:0] reg_rdata_o,
   input logic              irq_valid_o,
   input logic [LVL_W-1:0]  irq_level_o,
   input logic [IDX_W-1:0]  irq_src_o
);

   logic [N_SRC-1:0] pend_prev;
   logic [N_SRC-1:0] mask_prev;
   logic [N_SRC:0]   open_prev;

   always_ff @(posedge clk) begin
      pend_prev <= pend_i;
      mask_prev <= src_mask;
   end
   assign open_prev = {pend_prev & ~mask_prev, 1'b0};

   // R1
   fixed_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr_i != '0 && reg_addr_i <= IDX_W'(N_FIXED)) |->
      reg_rdata_o == DATA_W'({LVL_W'(reg_addr_i), PRI_W'(FIXED_PRI)}));

   // R4
   grant_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> open_prev[irq_src_o]);

   // R7
   grant_above_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid_o |-> (irq_level_o > $past(cpu_mask_i) || irq_level_o == '1));

   // R9
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_valid_o |-> (irq_level_o == '0 && irq_src_o == '0));

endmodule

bind irq_prioritizer irq_prioritizer_chk #(
   .N_SRC(N_SRC), .N_FIXED(N_FIXED), .FIXED_PRI(FIXED_PRI),
   .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pend_i     (pend_i),
   .cpu_mask_i (cpu_mask_i),
   .src_mask   (src_mask),
   .reg_addr_i (reg_addr_i),
   .reg_rdata_o(reg_rdata_o),
   .irq_valid_o(irq_valid_o),
   .irq_level_o(irq_level_o),
   .irq_src_o  (irq_src_o)
);

// File: tb/test_irq_prioritizer.sv
module test_irq_prioritizer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] pend = '0;
   logic [2:0]  cpu = '0;
   logic        we = 1'b0;
   logic [3:0]  addr = '0;
   logic [14:0] wdata = '0;
   logic [14:0] rdata;
   logic        v;
   logic [2:0]  lvl;
   logic [3:0]  src;

   always #(CLK_PERIOD / 2) clk = ~clk;

   irq_prioritizer i_irq_prioritizer (
      .clk(clk), .rst_n(rst_n), .pend_i(pend), .cpu_mask_i(cpu),
      .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_valid_o(v), .irq_level_o(lvl), .irq_src_o(src)
   );

   typedef struct {
      logic       v;
      logic [2:0] l;
      logic [3:0] s;
      string      tag;
   } item_t;

   item_t       q[$];
   item_t       got_item;
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;
   int          m_lvl[16];
   int          m_pri[16];
   logic [14:0] m_mask = '1;

   // Reference model built from the requirements
   function automatic item_t predict(string tag);
      item_t r;
      int    bk = -1;
      int    bs = 0;
      for (int s = 15; s >= 1; s--) begin
         int key = m_lvl[s] * 16 + m_pri[s];
         if (pend[s-1] && !m_mask[s-1] && m_lvl[s] != 0 && key >= bk) begin
            bk = key;
            bs = s;
         end
      end
      r.tag = tag;
      if (bs != 0 && (m_lvl[bs] > int'(cpu) || m_lvl[bs] == 7)) begin
         r.v = 1'b1; r.l = 3'(m_lvl[bs]); r.s = 4'(bs);
      end else begin
         r.v = 1'b0; r.l = '0; r.s = '0;
      end
      return r;
   endfunction

   // Monitor: compare queued expectations with the outputs
   always @(negedge clk) begin
      if (q.size() > 0) begin
         got_item = q.pop_front();
         checks++;
         if (v !== got_item.v || lvl !== got_item.l || src !== got_item.s) begin
            errors++;
            $display("FAIL %s: got v=%0d l=%0d s=%0d expected v=%0d l=%0d s=%0d",
                     got_item.tag, v, lvl, src, got_item.v, got_item.l, got_item.s);
         end
      end
   end

   task automatic stim(logic [14:0] p, logic [2:0] c, string tag);
      @(negedge clk);
      pend = p;
      cpu  = c;
      @(posedge clk);
      @(posedge clk);
      q.push_back(predict(tag));
      wait (q.size() == 0);
   endtask

   task automatic wr(logic [3:0] a, logic [14:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
      if (a == 0) m_mask = d;
      else if (a >= 8) begin
         m_lvl[a] = int'(d[6:4]);
         m_pri[a] = int'(d[3:0]);
      end
   endtask

   task automatic rd_chk(logic [3:0] a, logic [14:0] exp, string tag);
      @(negedge clk);
      addr = a;
      #1;
      checks++;
      if (rdata !== exp) begin
         errors++;
         $display("FAIL %s: readback addr %0d got %h expected %h", tag, a, rdata, exp);
      end
   endtask

   task automatic out_chk(logic ev, logic [2:0] el, logic [3:0] es, string tag);
      checks++;
      if (v !== ev || lvl !== el || src !== es) begin
         errors++;
         $display("FAIL %s: got v=%0d l=%0d s=%0d expected v=%0d l=%0d s=%0d",
                  tag, v, lvl, src, ev, el, es);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int s = 1; s <= 15; s++) begin
         m_lvl[s] = (s <= 7) ? s : 0;
         m_pri[s] = (s <= 7) ? 8 : 0;
      end
      m_lvl[0] = 0; m_pri[0] = 0;
      repeat (4) @(negedge clk);
      out_chk(1'b0, 3'd0, 4'd0, "R9 outputs in reset");
      rst_n = 1'b1;
      rd_chk(4'd0, 15'h7FFF, "R4 mask resets to all ones");
      rd_chk(4'd3, 15'h0038, "R1 hardwired entry 3");
      rd_chk(4'd8, 15'h0000, "R3 programmable entry resets to zero");
      stim(15'h7FFF, 3'd0, "R4 all sources masked");
      wr(4'd0, 15'h0000);
      stim(15'h0004, 3'd0, "R1 source 3 at level 3");
      stim(15'h007F, 3'd0, "R5 highest level wins");
      stim(15'h7FFF, 3'd0, "R8 programmable sources at level 0");
      stim(15'h0040, 3'd7, "R7 level 7 taken at mask 7");
      stim(15'h0020, 3'd6, "R7 level equal to mask blocked");
      stim(15'h0020, 3'd5, "R7 level above mask taken");
      wr(4'd0, 15'h0040);
      stim(15'h0040, 3'd0, "R4 level 7 source masked");
      wr(4'd0, 15'h0000);
      wr(4'd9, 15'h005C);
      rd_chk(4'd9, 15'h005C, "R3 entry 9 readback");
      stim(15'h0110, 3'd0, "R5 higher priority in level wins");
      wr(4'd9, 15'h0053);
      stim(15'h0110, 3'd0, "R5 lower priority loses");
      wr(4'd4, 15'h007F);
      rd_chk(4'd4, 15'h0048, "R2 write to entry 4 ignored");
      stim(15'h0108, 3'd0, "R2 source 4 still level 4");
      wr(4'd9, 15'h005C);
      wr(4'd10, 15'h005C);
      stim(15'h0300, 3'd0, "R6 duplicated pair, lower number");
      wr(4'd12, 15'h0038);
      stim(15'h0804, 3'd0, "R6 duplicate of hardwired pair");
      wr(4'd10, 15'h000C);
      stim(15'h0200, 3'd0, "R8 level 0 disables source 10");
      wr(4'd15, 15'h007F);
      wr(4'd0, 15'h4000);
      stim(15'h4000, 3'd7, "R4 programmable level 7 masked");
      wr(4'd0, 15'h0000);
      stim(15'h4000, 3'd7, "R7 programmable level 7 unmasked");
      @(negedge clk);
      pend = 15'h0002;
      cpu  = 3'd0;
      #1;
      out_chk(1'b1, 3'd7, 4'd15, "R9 output holds before edge");
      @(negedge clk);
      out_chk(1'b1, 3'd2, 4'd2, "R9 output updates after one edge");
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule